// File: doc/BRIEF.md
# Character Display Command Executor

This block is the command engine of a character display controller. A bus front end hands it one committed transfer at a time: an instruction byte, a data byte to store, a data read, or a status read. The executor decodes each transfer and keeps the controller state up to date. That state is the address counter, the choice between the character RAM (32 x 8) and the glyph RAM (16 x 5), the entry mode, the display, cursor and blink enables, the bus-width setting and a window offset for shifting the display. Both RAMs sit outside the block. The executor drives their write ports and their combinational read ports.

Reads are served from a one-byte prefetch register. The executor reloads it whenever the address moves under software control. A data read therefore hands back what was fetched earlier, so the first read after a data write yields stale data. The clear command and reset share a sequencer. It fills every character location with the space code 20h while the busy flag is held high. During that time every transfer except a status read is dropped.

Top module: `cmd_exec_core`

## Requirements
- R1: While `rst` is high and for the fill period that follows it, `busy` is 1. When `busy` falls after reset, every character RAM location holds 20h, the address counter is 0, increment mode is on, auto-shift is off, display, cursor and blink are off, the bus-width flag is 1 and the window offset is 0.
- R2: An instruction (`cmd_rs`=0, `cmd_rd`=0) is decoded by its highest set bit. 1xxA_AAAA sets the character address. 01xx_AAAA sets the glyph address. 001W_xxxx sets the bus width to W. 0001_SRxx is a shift. 0000_1DCB sets display D, cursor C and blink B. 0000_01IH sets increment I and auto-shift H. 0000_001x returns home. 0000_0001 clears. 0000_0000 does nothing.
- R3: Clear writes 20h to all 32 character locations and sets the address to 0, selects the character RAM, sets increment mode and sets the window offset to 0. It keeps `busy` high for exactly CLR_CYCLES (34) cycles, and afterwards a data read returns 20h.
- R4: Return home sets the address to 0 in the character RAM and the window offset to 0. It leaves the RAM contents unchanged.
- R5: A data write (`cmd_rs`=1, `cmd_rd`=0) stores the byte at the current address and then steps the address by +1 when increment mode is on or by -1 when it is off. The address wraps modulo 32 in the character RAM and modulo 16 in the glyph RAM. The glyph RAM keeps only the low 5 bits.
- R6: A data read (`cmd_rs`=1, `cmd_rd`=1) returns the current prefetch byte on `rd_data`, steps the address like a write, and then reloads the prefetch from the new address. Glyph bytes read back with bits 7..5 at zero.
- R7: The window offset moves only on a character RAM write with auto-shift on: +1 in increment mode and -1 otherwise, wrapping modulo 32. Reads and glyph writes leave it unchanged.
- R8: A shift instruction with S=0 steps the address by -1 when R=0 or by +1 when R=1. With S=1 it moves the window offset by +1 when R=0 or by -1 when R=1, and leaves the address unchanged.
- R9: An address set, and a character-RAM cursor shift, reload the prefetch register from the new address. The next data read returns that location.
- R10: While `busy` is 1, only status reads take effect. A status read (`cmd_rs`=0, `cmd_rd`=1) returns {busy, 00, address} on `rd_data`. A command that reloads the prefetch holds `busy` for one extra cycle.
- R11: The display, cursor, blink and bus-width outputs follow the last accepted display-control and width instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a committed transfer |
| cmd_rs | input | 1 | 1 = data transfer, 0 = instruction/status |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_byte | input | 8 | Instruction or data byte |
| rd_data | output | 8 | Result of the last read or status read |
| busy | output | 1 | Internal operation in progress |
| ac | output | 5 | Address counter |
| cg_sel | output | 1 | 1 = glyph RAM selected |
| inc_mode | output | 1 | Address steps up after data access |
| shift_en | output | 1 | Auto-shift on character writes |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| bus_wide | output | 1 | Bus width flag (1 = byte wide) |
| shift_ofs | output | 5 | Display window offset |
| dd_we | output | 1 | Character RAM write enable |
| dd_waddr | output | 5 | Character RAM write address |
| dd_wdata | output | 8 | Character RAM write data |
| dd_raddr | output | 5 | Character RAM read address |
| dd_rdata | input | 8 | Character RAM read data (combinational) |
| cg_we | output | 1 | Glyph RAM write enable |
| cg_waddr | output | 4 | Glyph RAM write address |
| cg_wdata | output | 5 | Glyph RAM write data |
| cg_raddr | output | 4 | Glyph RAM read address |
| cg_rdata | input | 5 | Glyph RAM read data (combinational) |

## Verification
Writes are tested in ascending order across the top of the character space, which separates correct modulo-32 wrapping from saturation. Descending writes across zero test the decrement path, and a descending glyph write tests the narrower modulo-16 wrap. Auto-shift is exercised through a mix of character writes, character reads and glyph writes, so an offset that moves on the wrong access type is caught. The four shift opcodes are run back to back, which tells address movement apart from window movement. Commands issued during a clear check that a busy executor drops them, while status reads still report the busy flag.

// File: rtl/cmd_exec_pkg.sv
package cmd_exec_pkg;

    localparam logic [7:0] SPACE_CODE = 8'h20;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_WIDTH,
        OP_CG_ADDR,
        OP_DD_ADDR,
        OP_WR_DATA,
        OP_RD_DATA,
        OP_STATUS
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] arg;
    } cmd_t;

    typedef struct packed {
        logic inc;
        logic shift_en;
        logic disp;
        logic cursor;
        logic blink;
        logic wide;
    } mode_t;

    localparam mode_t MODE_RESET = '{inc: 1'b1, shift_en: 1'b0, disp: 1'b0,
                                     cursor: 1'b0, blink: 1'b0, wide: 1'b1};

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmd_exec_pkg::*;
(
    input  logic       is_data,
    input  logic       is_read,
    input  logic [7:0] code,
    output cmd_t       cmd
);
    always_comb begin
        cmd.arg = code;
        if (is_data) begin
            cmd.op = is_read ? OP_RD_DATA : OP_WR_DATA;
        end else if (is_read) begin
            cmd.op = OP_STATUS;
        end else begin
            casez (code)
                8'b1???????: cmd.op = OP_DD_ADDR;
                8'b01??????: cmd.op = OP_CG_ADDR;
                8'b001?????: cmd.op = OP_WIDTH;
                8'b0001????: cmd.op = OP_SHIFT;
                8'b00001???: cmd.op = OP_DISP;
                8'b000001??: cmd.op = OP_ENTRY;
                8'b0000001?: cmd.op = OP_HOME;
                8'b00000001: cmd.op = OP_CLEAR;
                default:     cmd.op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ac_step.sv
module ac_step #(
    parameter int AW  = 5,
    parameter int NAW = 4
) (
    input  logic [AW-1:0] cur,
    input  logic          up,
    input  logic          narrow,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] NMASK = AW'((1 << NAW) - 1);
    logic [AW-1:0] raw;

    always_comb begin
        raw = up ? cur + 1'b1 : cur - 1'b1;
        nxt = narrow ? (raw & NMASK) : raw;
    end
endmodule

// File: rtl/clr_fill.sv
module clr_fill #(
    parameter int DEPTH  = 32,
    parameter int CYCLES = 34,
    localparam int CW = $clog2(CYCLES),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          active,
    output logic          we,
    output logic          last,
    output logic [AW-1:0] addr
);
    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == CW'(CYCLES - 1)) begin
                run <= 1'b0;
            end
            cnt <= cnt + 1'b1;
        end
    end

    assign active = run;
    assign we     = run && (cnt < CW'(DEPTH));
    assign last   = run && (cnt == CW'(CYCLES - 1));
    assign addr   = cnt[AW-1:0];
endmodule

// File: rtl/cmd_exec_core.sv
module cmd_exec_core
    import cmd_exec_pkg::*;
#(
    parameter int DD_AW      = 5,
    parameter int CG_AW      = 4,
    parameter int CG_DW      = 5,
    parameter int CLR_CYCLES = 34,
    localparam int DD_DEPTH  = 1 << DD_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_rs,
    input  logic             cmd_rd,
    input  logic [7:0]       cmd_byte,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic [DD_AW-1:0] ac,
    output logic             cg_sel,
    output logic             inc_mode,
    output logic             shift_en,
    output logic             disp_on,
    output logic             cursor_on,
    output logic             blink_on,
    output logic             bus_wide,
    output logic [DD_AW-1:0] shift_ofs,
    output logic             dd_we,
    output logic [DD_AW-1:0] dd_waddr,
    output logic [7:0]       dd_wdata,
    output logic [DD_AW-1:0] dd_raddr,
    input  logic [7:0]       dd_rdata,
    output logic             cg_we,
    output logic [CG_AW-1:0] cg_waddr,
    output logic [CG_DW-1:0] cg_wdata,
    output logic [CG_AW-1:0] cg_raddr,
    input  logic [CG_DW-1:0] cg_rdata
);
    cmd_t             cmd;
    mode_t            mode;
    logic [DD_AW-1:0] ac_q, ofs_q;
    logic             cg_q, refill_q;
    logic [7:0]       pref_q, rd_q;
    logic             fill_active, fill_we, fill_last, fill_start;
    logic [DD_AW-1:0] fill_addr;
    logic [DD_AW-1:0] ac_data_nxt, ac_cur_nxt;
    logic             accept;
    logic [7:0]       ram_word;

    cmd_decode u_dec (
        .is_data (cmd_rs),
        .is_read (cmd_rd),
        .code    (cmd_byte),
        .cmd     (cmd)
    );

    // address step after a data access follows the entry mode
    ac_step #(.AW(DD_AW), .NAW(CG_AW)) u_step_data (
        .cur    (ac_q),
        .up     (mode.inc),
        .narrow (cg_q),
        .nxt    (ac_data_nxt)
    );

    // address step for a cursor shift follows the R bit of the opcode
    ac_step #(.AW(DD_AW), .NAW(CG_AW)) u_step_cursor (
        .cur    (ac_q),
        .up     (cmd.arg[2]),
        .narrow (cg_q),
        .nxt    (ac_cur_nxt)
    );

    clr_fill #(.DEPTH(DD_DEPTH), .CYCLES(CLR_CYCLES)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .start  (fill_start),
        .active (fill_active),
        .we     (fill_we),
        .last   (fill_last),
        .addr   (fill_addr)
    );

    assign busy       = fill_active | refill_q;
    assign accept     = cmd_valid && !busy;
    assign fill_start = accept && (cmd.op == OP_CLEAR);

    always_comb begin
        dd_we    = fill_we | (accept && cmd.op == OP_WR_DATA && !cg_q);
        dd_waddr = fill_we ? fill_addr : ac_q;
        dd_wdata = fill_we ? SPACE_CODE : cmd.arg;
        dd_raddr = fill_last ? '0 : ac_q;
        cg_we    = accept && cmd.op == OP_WR_DATA && cg_q;
        cg_waddr = ac_q[CG_AW-1:0];
        cg_wdata = cmd.arg[CG_DW-1:0];
        cg_raddr = ac_q[CG_AW-1:0];
        ram_word = cg_q ? {{(8-CG_DW){1'b0}}, cg_rdata} : dd_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q     <= '0;
            ofs_q    <= '0;
            cg_q     <= 1'b0;
            refill_q <= 1'b0;
            pref_q   <= '0;
            rd_q     <= '0;
            mode     <= MODE_RESET;
        end else begin
            refill_q <= 1'b0;
            if (fill_last) begin
                pref_q <= dd_rdata;
            end
            if (refill_q) begin
                pref_q <= ram_word;
            end
            if (cmd_valid && cmd.op == OP_STATUS) begin
                rd_q <= {busy, {(7-DD_AW){1'b0}}, ac_q};
            end else if (accept) begin
                unique case (cmd.op)
                    OP_CLEAR: begin
                        ac_q     <= '0;
                        cg_q     <= 1'b0;
                        ofs_q    <= '0;
                        mode.inc <= 1'b1;
                    end
                    OP_HOME: begin
                        ac_q     <= '0;
                        cg_q     <= 1'b0;
                        ofs_q    <= '0;
                        refill_q <= 1'b1;
                    end
                    OP_ENTRY: begin
                        mode.inc      <= cmd.arg[1];
                        mode.shift_en <= cmd.arg[0];
                    end
                    OP_DISP: begin
                        mode.disp   <= cmd.arg[2];
                        mode.cursor <= cmd.arg[1];
                        mode.blink  <= cmd.arg[0];
                    end
                    OP_SHIFT: begin
                        if (cmd.arg[3]) begin
                            ofs_q <= cmd.arg[2] ? ofs_q - 1'b1 : ofs_q + 1'b1;
                        end else begin
                            ac_q     <= ac_cur_nxt;
                            refill_q <= !cg_q;
                        end
                    end
                    OP_WIDTH: mode.wide <= cmd.arg[4];
                    OP_CG_ADDR: begin
                        ac_q     <= DD_AW'(cmd.arg[CG_AW-1:0]);
                        cg_q     <= 1'b1;
                        refill_q <= 1'b1;
                    end
                    OP_DD_ADDR: begin
                        ac_q     <= cmd.arg[DD_AW-1:0];
                        cg_q     <= 1'b0;
                        refill_q <= 1'b1;
                    end
                    OP_WR_DATA: begin
                        ac_q <= ac_data_nxt;
                        if (!cg_q && mode.shift_en) begin
                            ofs_q <= mode.inc ? ofs_q + 1'b1 : ofs_q - 1'b1;
                        end
                    end
                    OP_RD_DATA: begin
                        rd_q     <= pref_q;
                        ac_q     <= ac_data_nxt;
                        refill_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_data   = rd_q;
    assign ac        = ac_q;
    assign cg_sel    = cg_q;
    assign inc_mode  = mode.inc;
    assign shift_en  = mode.shift_en;
    assign disp_on   = mode.disp;
    assign cursor_on = mode.cursor;
    assign blink_on  = mode.blink;
    assign bus_wide  = mode.wide;
    assign shift_ofs = ofs_q;
endmodule

// File: rtl/cmd_exec_chk.sv
module cmd_exec_chk #(
    parameter int AW    = 5,
    parameter int CG_AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          busy,
    input logic          dd_we,
    input logic [7:0]    dd_wdata,
    input logic          cg_we,
    input logic          cg_sel,
    input logic [AW-1:0] ac,
    input logic [AW-1:0] shift_ofs
);
    // R1
    reset_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy);

    // R3
    fill_space_chk: assert property (@(posedge clk) disable iff (rst)
        (dd_we && busy) |-> (dd_wdata == 8'h20));

    // R5
    one_ram_chk: assert property (@(posedge clk) disable iff (rst)
        !(dd_we && cg_we));

    // R5
    cg_range_chk: assert property (@(posedge clk) disable iff (rst)
        cg_sel |-> (ac < AW'(1 << CG_AW)));

    // R10
    busy_glyph_chk: assert property (@(posedge clk) disable iff (rst)
        cg_we |-> !busy);

    // R7
    ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_valid) |-> $stable(shift_ofs));
endmodule

bind cmd_exec_core cmd_exec_chk #(.AW(DD_AW), .CG_AW(CG_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .dd_we     (dd_we),
    .dd_wdata  (dd_wdata),
    .cg_we     (cg_we),
    .cg_sel    (cg_sel),
    .ac        (ac),
    .shift_ofs (shift_ofs)
);

// File: tb/cmd_exec_core_test.sv
module cmd_exec_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLR_N      = 34;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0, cmd_rs = 1'b0, cmd_rd = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [7:0] rd_data;
    logic       busy, cg_sel, inc_mode, shift_en, disp_on, cursor_on, blink_on, bus_wide;
    logic [4:0] ac, shift_ofs;
    logic       dd_we, cg_we;
    logic [4:0] dd_waddr, dd_raddr;
    logic [7:0] dd_wdata, dd_rdata;
    logic [3:0] cg_waddr, cg_raddr;
    logic [4:0] cg_wdata, cg_rdata;

    logic [7:0] dd_mem [32];
    logic [4:0] cg_mem [16];
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (dd_we) dd_mem[dd_waddr] <= dd_wdata;
        if (cg_we) cg_mem[cg_waddr] <= cg_wdata;
    end
    assign dd_rdata = dd_mem[dd_raddr];
    assign cg_rdata = cg_mem[cg_raddr];

    cmd_exec_core uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs), .cmd_rd(cmd_rd),
        .cmd_byte(cmd_byte), .rd_data(rd_data), .busy(busy), .ac(ac), .cg_sel(cg_sel),
        .inc_mode(inc_mode), .shift_en(shift_en), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .bus_wide(bus_wide), .shift_ofs(shift_ofs),
        .dd_we(dd_we), .dd_waddr(dd_waddr), .dd_wdata(dd_wdata), .dd_raddr(dd_raddr),
        .dd_rdata(dd_rdata), .cg_we(cg_we), .cg_waddr(cg_waddr), .cg_wdata(cg_wdata),
        .cg_raddr(cg_raddr), .cg_rdata(cg_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic rs, input logic rd, input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_rs = rs; cmd_rd = rd; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        if (busy) check("R10 busy stuck", 8'(busy), 8'h0);
    endtask

    task automatic instr(input logic [7:0] b); issue(1'b0, 1'b0, b); wait_idle(); endtask
    task automatic wr(input logic [7:0] b);    issue(1'b1, 1'b0, b); wait_idle(); endtask
    task automatic rdd();                      issue(1'b1, 1'b1, 8'h00); wait_idle(); endtask

    task automatic all_space(input string req);
        int bad = 0;
        for (int i = 0; i < 32; i++) if (dd_mem[i] !== 8'h20) bad++;
        check(req, 8'(bad), 8'h00);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) dd_mem[i] = 8'hFF;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 8'(busy), 8'h1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 8'(busy), 8'h1);
        wait_idle();
        all_space("R1 ram filled");
        check("R1 ac", 8'(ac), 8'h00);
        check("R1 mode", {2'b0, inc_mode, shift_en, disp_on, cursor_on, blink_on, bus_wide}, 8'b0010_0001);
        check("R1 offset", 8'(shift_ofs), 8'h00);
    endtask

    task automatic t_write_wrap();
        instr(8'h9E);
        wr(8'h41); wr(8'h42); wr(8'h43);
        check("R5 write 1E", dd_mem[30], 8'h41);
        check("R5 write 1F", dd_mem[31], 8'h42);
        check("R5 wrap to 00", dd_mem[0], 8'h43);
        check("R2 R5 ac after wrap", 8'(ac), 8'h01);
    endtask

    task automatic t_read();
        instr(8'h9E);
        rdd(); check("R9 R6 first read", rd_data, 8'h41);
        rdd(); check("R6 second read", rd_data, 8'h42);
        issue(1'b0, 1'b1, 8'h00); wait_idle();
        check("R10 status idle", rd_data, 8'h00);
        rdd(); check("R6 read after wrap", rd_data, 8'h43);
    endtask

    task automatic t_decrement();
        instr(8'h04);
        check("R2 entry dec", 8'(inc_mode), 8'h0);
        instr(8'h81);
        wr(8'h58); wr(8'h59);
        check("R5 dec write 01", dd_mem[1], 8'h58);
        check("R5 dec write 00", dd_mem[0], 8'h59);
        check("R5 dec wrap ac", 8'(ac), 8'h1F);
    endtask

    task automatic t_autoshift();
        check("R7 offset start", 8'(shift_ofs), 8'h00);
        instr(8'h07);
        instr(8'h90);
        wr(8'h61);
        check("R7 shift left", 8'(shift_ofs), 8'h01);
        rdd();
        check("R7 read no shift", 8'(shift_ofs), 8'h01);
        instr(8'h05);
        wr(8'h62);
        check("R7 shift right", 8'(shift_ofs), 8'h00);
        wr(8'h63);
        check("R7 right wrap", 8'(shift_ofs), 8'h1F);
        instr(8'h40);
        wr(8'h64);
        check("R7 glyph no shift", 8'(shift_ofs), 8'h1F);
        check("R5 glyph dec wrap16", 8'(ac), 8'h0F);
    endtask

    task automatic t_glyph();
        instr(8'h06);
        instr(8'h4F);
        wr(8'hFF);
        check("R5 glyph low bits", 8'(cg_mem[15]), 8'h1F);
        check("R5 glyph inc wrap16", 8'(ac), 8'h00);
        check("R2 glyph select", 8'(cg_sel), 8'h1);
        instr(8'h4F);
        rdd();
        check("R6 glyph read zero top", rd_data, 8'h1F);
    endtask

    task automatic t_cursor();
        instr(8'h84);
        wr(8'h77);
        instr(8'h10);
        check("R8 cursor left", 8'(ac), 8'h04);
        rdd();
        check("R9 cursor refill", rd_data, 8'h77);
        instr(8'h14);
        check("R8 cursor right", 8'(ac), 8'h06);
        instr(8'h18);
        check("R8 window left", 8'(shift_ofs), 8'h00);
        check("R8 window keeps ac", 8'(ac), 8'h06);
        instr(8'h1C);
        check("R8 window right", 8'(shift_ofs), 8'h1F);
    endtask

    task automatic t_home();
        logic [7:0] keep = dd_mem[6];
        instr(8'h03);
        check("R4 home ac", 8'(ac), 8'h00);
        check("R4 home offset", 8'(shift_ofs), 8'h00);
        check("R4 ram kept", dd_mem[6], keep);
    endtask

    task automatic t_modes();
        instr(8'h0D);
        check("R11 disp D C B", {5'b0, disp_on, cursor_on, blink_on}, 8'b101);
        instr(8'h0A);
        check("R11 disp D C B 2", {5'b0, disp_on, cursor_on, blink_on}, 8'b010);
        instr(8'h2F);
        check("R11 width low", 8'(bus_wide), 8'h0);
        instr(8'h30);
        check("R11 width high", 8'(bus_wide), 8'h1);
        instr(8'h00);
        check("R2 nop keeps mode", {5'b0, disp_on, cursor_on, blink_on}, 8'b010);
    endtask

    task automatic t_clear();
        int cnt = 0;
        instr(8'h04); instr(8'h18); instr(8'h87);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_rs = 1'b0; cmd_rd = 1'b0; cmd_byte = 8'h01;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check("R3 busy length", 8'(cnt), 8'(CLR_N));
        all_space("R3 ram filled");
        check("R3 ac", 8'(ac), 8'h00);
        check("R3 inc forced", 8'(inc_mode), 8'h1);
        check("R3 offset", 8'(shift_ofs), 8'h00);
        rdd();
        check("R3 read space", rd_data, 8'h20);
    endtask

    task automatic t_busy_ignore();
        instr(8'h87);
        issue(1'b0, 1'b0, 8'h01);
        issue(1'b1, 1'b0, 8'h55);
        issue(1'b0, 1'b0, 8'h04);
        issue(1'b0, 1'b1, 8'h00);
        check("R10 status busy", rd_data, 8'h80);
        wait_idle();
        check("R10 write dropped ac", 8'(ac), 8'h00);
        check("R10 entry dropped", 8'(inc_mode), 8'h1);
        all_space("R10 write dropped ram");
    endtask

    initial begin
        t_reset();
        t_write_wrap();
        t_read();
        t_decrement();
        t_autoshift();
        t_glyph();
        t_cursor();
        t_home();
        t_modes();
        t_clear();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule